// File: doc/BRIEF.md
# Per-Timeslot PCM Channel Conditioner

This block sits in the transmit path of a T1 framer, between the PCM source and the framing logic. Each cycle in which the valid strobe is high it takes one 8-bit PCM byte together with the index of the time slot it belongs to. Each of the 24 slots has its own 4-bit control code, and that code decides what happens to the byte. The byte can pass unchanged, or have all of its bits inverted, or only its even bits, or only its odd bits. It can also be replaced by a fixed pattern, by a busy pattern chosen per slot, or by an 8-bit user code that is also programmed per slot.

A single write port loads the control code or the user code of one slot. The conditioned byte leaves one clock later, together with its slot index and a delayed valid strobe. Framing-bit insertion, zero suppression, line coding and signalling are handled by other blocks.

Top module: `pcm_slot_conditioner`

## Requirements
- R1: After a synchronous reset `out_valid` is low and every slot's control code is 0, so a byte sent to any slot comes out unchanged.
- R2: `out_valid`, `out_slot` and `out_data` are registered. A byte accepted with `in_valid` high appears exactly one cycle later with `out_valid` high and `out_slot` equal to its index. In a cycle with `in_valid` low, `out_valid` is low one cycle later.
- R3: Control code 0 (4'b0000) passes the byte unchanged, and so do the unused codes 9 to 15.
- R4: Control code 1 outputs the bitwise complement of the byte.
- R5: Bits are numbered 0 to 7, with bit 0 the LSB. Code 2 inverts bits 0, 2, 4 and 6 (XOR 0x55). Code 3 inverts bits 1, 3, 5 and 7 (XOR 0xAA).
- R6: Code 4 replaces the byte with that slot's user code. A user code is written with `cfg_sel`=1; a control code is written with `cfg_sel`=0, which loads `cfg_data[3:0]`.
- R7: Code 5 outputs 0x7F, code 6 outputs 0xFF and code 8 outputs 0x1A.
- R8: Code 7 outputs the slot's busy pattern. Slot 0 always uses 0xE0. Every other slot uses its entry in the `BUSY_TABLE` parameter, whose default is 0xE0 for every slot.
- R9: A configuration write in the same cycle as a byte for the same slot does not affect that byte. It takes effect from the next byte for that slot.
- R10: A byte whose slot index is 24 or more passes unchanged, and a write to such an index changes no slot.
- R11: Writing one slot's control code or user code does not change how any other slot is conditioned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_slot | input | 5 | Time-slot index of the input byte |
| in_data | input | 8 | Input PCM byte |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0: write the control code, 1: write the user code |
| cfg_slot | input | 5 | Slot addressed by the write |
| cfg_data | input | 8 | Write data (bits 3:0 for a control code) |
| out_valid | output | 1 | Output byte strobe |
| out_slot | output | 5 | Time-slot index of the output byte |
| out_data | output | 8 | Conditioned PCM byte |

## Verification
A corrupted control-code entry shows up in the next byte sent to that slot, one cycle after it is accepted, as the wrong transform. A substitution code gives itself away whatever the data is. An inversion code is seen only against known input data. A write that lands in the wrong slot, or that aliases an out-of-range index, shows up as a neighbouring slot changing behaviour, so the tests read back several slots after each write. Pipeline faults show up at once as a misaligned `out_slot` or a stray `out_valid`.

// File: rtl/pcm_cond_pkg.sv
package pcm_cond_pkg;
  localparam int PCM_W = 8;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CC_PASS     = 4'd0,
    CC_INV_ALL  = 4'd1,
    CC_INV_EVEN = 4'd2,
    CC_INV_ODD  = 4'd3,
    CC_USER     = 4'd4,
    CC_BUSY     = 4'd5,
    CC_VACANT   = 4'd6,
    CC_BUSY_TS  = 4'd7,
    CC_MOOF     = 4'd8
  } cond_code_e;

  localparam logic [PCM_W-1:0] MASK_EVEN   = 8'h55;
  localparam logic [PCM_W-1:0] MASK_ODD    = 8'hAA;
  localparam logic [PCM_W-1:0] PAT_BUSY    = 8'h7F;
  localparam logic [PCM_W-1:0] PAT_VACANT  = 8'hFF;
  localparam logic [PCM_W-1:0] PAT_MOOF    = 8'h1A;
  localparam logic [PCM_W-1:0] PAT_TS0     = 8'hE0;
endpackage

// File: rtl/pcm_cond_cfg_regs.sv
module pcm_cond_cfg_regs
  import pcm_cond_pkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_user,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [PCM_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [CODE_W-1:0] rd_code,
  output logic [PCM_W-1:0]  rd_user
);
  localparam logic [SLOT_W:0] SLOT_LIMIT = NUM_SLOTS[SLOT_W:0];

  logic [CODE_W-1:0] ctl_q  [NUM_SLOTS];
  logic [PCM_W-1:0]  user_q [NUM_SLOTS];

  logic wr_ok, rd_ok;
  assign wr_ok = wr_en && ({1'b0, wr_slot} < SLOT_LIMIT);
  assign rd_ok = {1'b0, rd_slot} < SLOT_LIMIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) ctl_q[i] <= '0;
    end else if (wr_ok && !wr_user) begin
      ctl_q[wr_slot] <= wr_data[CODE_W-1:0];
    end
  end

  // user codes carry no reset so the array maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_ok && wr_user) user_q[wr_slot] <= wr_data;
  end

  always_comb begin
    rd_code = '0;
    rd_user = '0;
    if (rd_ok) begin
      rd_code = ctl_q[rd_slot];
      rd_user = user_q[rd_slot];
    end
  end
endmodule

// File: rtl/pcm_cond_busy_rom.sv
module pcm_cond_busy_rom
  import pcm_cond_pkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter logic [NUM_SLOTS*PCM_W-1:0] BUSY_TABLE = {NUM_SLOTS{8'hE0}}
) (
  input  logic [SLOT_W-1:0] slot,
  output logic [PCM_W-1:0]  pattern
);
  localparam logic [SLOT_W:0] SLOT_LIMIT = NUM_SLOTS[SLOT_W:0];

  logic [PCM_W-1:0] rom [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_rom
    if (g == 0) begin : g_ts0
      assign rom[g] = PAT_TS0;
    end else begin : g_tab
      assign rom[g] = BUSY_TABLE[g*PCM_W +: PCM_W];
    end
  end

  assign pattern = ({1'b0, slot} < SLOT_LIMIT) ? rom[slot] : PAT_TS0;
endmodule

// File: rtl/pcm_cond_transform.sv
module pcm_cond_transform
  import pcm_cond_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [PCM_W-1:0]  din,
  input  logic [PCM_W-1:0]  user_code,
  input  logic [PCM_W-1:0]  busy_pat,
  output logic [PCM_W-1:0]  dout
);
  cond_code_e sel;
  assign sel = cond_code_e'(code);

  always_comb begin
    case (sel)
      CC_INV_ALL:  dout = ~din;
      CC_INV_EVEN: dout = din ^ MASK_EVEN;
      CC_INV_ODD:  dout = din ^ MASK_ODD;
      CC_USER:     dout = user_code;
      CC_BUSY:     dout = PAT_BUSY;
      CC_VACANT:   dout = PAT_VACANT;
      CC_BUSY_TS:  dout = busy_pat;
      CC_MOOF:     dout = PAT_MOOF;
      default:     dout = din;
    endcase
  end
endmodule

// File: rtl/pcm_slot_conditioner.sv
module pcm_slot_conditioner
  import pcm_cond_pkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter logic [NUM_SLOTS*PCM_W-1:0] BUSY_TABLE = {NUM_SLOTS{8'hE0}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [PCM_W-1:0]  in_data,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [PCM_W-1:0]  cfg_data,
  output logic              out_valid,
  output logic [SLOT_W-1:0] out_slot,
  output logic [PCM_W-1:0]  out_data
);
  logic [CODE_W-1:0] rd_code;
  logic [PCM_W-1:0]  rd_user;
  logic [PCM_W-1:0]  busy_pat;
  logic [PCM_W-1:0]  cond_byte;

  pcm_cond_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_user(cfg_sel), .wr_slot(cfg_slot), .wr_data(cfg_data),
    .rd_slot(in_slot), .rd_code(rd_code), .rd_user(rd_user)
  );

  pcm_cond_busy_rom #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W),
                      .BUSY_TABLE(BUSY_TABLE)) u_busy (
    .slot(in_slot), .pattern(busy_pat)
  );

  pcm_cond_transform u_xform (
    .code(rd_code), .din(in_data), .user_code(rd_user),
    .busy_pat(busy_pat), .dout(cond_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_slot  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_slot <= in_slot;
        out_data <= cond_byte;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_conditioner_chk.sv
module pcm_slot_conditioner_chk
  import pcm_cond_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SLOT_W-1:0] in_slot,
  input logic [PCM_W-1:0]  in_data,
  input logic [CODE_W-1:0] rd_code,
  input logic              out_valid,
  input logic [SLOT_W-1:0] out_slot,
  input logic [PCM_W-1:0]  out_data
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_SLOT_ECHO: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_slot == $past(in_slot)); // R2
  AST_INVERT_ALL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_code == 4'd1) |=> out_data == ~$past(in_data)); // R4
  AST_FIXED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_code == 4'd5) |=> out_data == 8'h7F); // R7
  AST_FIXED_VACANT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_code == 4'd6) |=> out_data == 8'hFF); // R7
  AST_FIXED_MOOF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_code == 4'd8) |=> out_data == 8'h1A); // R7
  AST_HIGH_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_code > 4'd8) |=> out_data == $past(in_data)); // R3
endmodule

bind pcm_slot_conditioner pcm_slot_conditioner_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_slot(in_slot),
  .in_data(in_data), .rd_code(rd_code), .out_valid(out_valid),
  .out_slot(out_slot), .out_data(out_data)
);

// File: tb/test_pcm_slot_conditioner.sv
`timescale 1ns/1ps
module test_pcm_slot_conditioner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [4:0] in_slot = '0;
  logic [7:0] in_data = '0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [4:0] cfg_slot = '0;
  logic [7:0] cfg_data = '0;
  logic       out_valid;
  logic [4:0] out_slot;
  logic [7:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcm_slot_conditioner i_pcm_slot_conditioner (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_slot(in_slot),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_slot(cfg_slot), .cfg_data(cfg_data), .out_valid(out_valid),
    .out_slot(out_slot), .out_data(out_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit user, input int slot, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = user; cfg_slot = 5'(slot); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // send one byte, check the registered result one cycle later
  task automatic xfer(input string req, input int slot, input int data, input int exp);
    @(negedge clk);
    in_valid = 1'b1; in_slot = 5'(slot); in_data = 8'(data);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " slot"}, int'(out_slot), slot);
    chk({req, " data"}, int'(out_data), exp);
  endtask

  task automatic t_reset;
    chk("R1 out_valid after reset", int'(out_valid), 0);
    for (int s = 0; s < 24; s += 7) xfer("R1 reset pass", s, 8'h3C + s, 8'h3C + s);
  endtask

  task automatic t_pipe;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 idle out_valid", int'(out_valid), 0);
    xfer("R2 latency", 23, 8'h81, 8'h81);
  endtask

  task automatic t_pass_codes;
    wr(0, 2, 0);
    xfer("R3 code0", 2, 8'h96, 8'h96);
    for (int c = 9; c < 16; c++) begin
      wr(0, 2, c);
      xfer("R3 high code", 2, 8'h4B + c, 8'h4B + c);
    end
  endtask

  task automatic t_invert;
    wr(0, 5, 1);
    xfer("R4 invert", 5, 8'hA3, 8'h5C);
    xfer("R4 invert zero", 5, 8'h00, 8'hFF);
    wr(0, 6, 2);
    xfer("R5 even", 6, 8'h0F, 8'h5A);
    wr(0, 7, 3);
    xfer("R5 odd", 7, 8'h0F, 8'hA5);
  endtask

  task automatic t_user;
    wr(1, 9, 8'hC7);
    wr(0, 9, 4);
    xfer("R6 user", 9, 8'h11, 8'hC7);
    wr(1, 9, 8'h2D);
    xfer("R6 user rewrite", 9, 8'h11, 8'h2D);
  endtask

  task automatic t_fixed;
    wr(0, 10, 5);
    xfer("R7 busy", 10, 8'h00, 8'h7F);
    wr(0, 11, 6);
    xfer("R7 vacant", 11, 8'h12, 8'hFF);
    wr(0, 12, 8);
    xfer("R7 moof", 12, 8'hFF, 8'h1A);
  endtask

  task automatic t_busy_ts;
    wr(0, 0, 7);
    xfer("R8 slot0 busy", 0, 8'h55, 8'hE0);
    wr(0, 17, 7);
    xfer("R8 slot17 busy", 17, 8'h01, 8'hE0);
  endtask

  task automatic t_same_cycle;
    wr(0, 3, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_slot = 5'd3; cfg_data = 8'd1;
    in_valid = 1'b1; in_slot = 5'd3; in_data = 8'hA5;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R9 same-cycle old code", int'(out_data), 8'hA5);
    xfer("R9 next occurrence", 3, 8'hA5, 8'h5A);
  endtask

  task automatic t_range;
    wr(0, 24, 6);
    wr(0, 31, 5);
    xfer("R10 slot24 pass", 24, 8'h3E, 8'h3E);
    xfer("R10 slot31 pass", 31, 8'h77, 8'h77);
    xfer("R10 slot0 untouched", 0, 8'h55, 8'hE0);
    xfer("R10 slot7 untouched", 7, 8'h0F, 8'hA5);
    xfer("R10 slot15 untouched", 15, 8'h6C, 8'h6C);
  endtask

  task automatic t_indep;
    wr(0, 13, 1);
    wr(1, 14, 8'h99);
    xfer("R11 slot12 keeps moof", 12, 8'h44, 8'h1A);
    xfer("R11 slot14 pass", 14, 8'h44, 8'h44);
    xfer("R11 slot9 user kept", 9, 8'h44, 8'h2D);
    xfer("R11 slot13 invert", 13, 8'h44, 8'hBB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pipe();
    t_pass_codes();
    t_invert();
    t_user();
    t_fixed();
    t_busy_ts();
    t_same_cycle();
    t_range();
    t_indep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule